// File: doc/BRIEF.md
# Teletext Serial Insertion Timing Generator

This block runs on the 27 MHz pixel clock and collects one vertical-blanking line of teletext from an upstream source that sends serial data at a nominal 6.9375 Mb/s. Forty-five bytes (360 bits) make up a line: run-in clock, address and payload. The two rates do not divide evenly. To follow them, the block gives each bit a cell of four pixel clocks, except the 10th, 19th, 28th and 37th bit of every 37-bit group, which get three. Every 37 bits therefore take exactly 144 pixel clocks.

A line-start strobe opens a line. The serial data comes in on one of three input pins, chosen by a two-bit select. Each bit is sampled at the last clock of its cell and presented with a one-cycle valid strobe. A request output tells the source when to send. It has two forms: one window for the whole line, or one pulse inside every bit cell. A four-bit offset and a four-bit width configure it. A one-cycle done flag marks the end of the line. The block runs only while both the insertion enable and the PAL-standard input are high.

Top module: `txt_ins_timer`

## Requirements
- R1: During reset and after it, `req`, `bit_vld`, `bit_out` and `line_done` are 0. A reset in the middle of a line ends the line, and no further bits or done flag appear.
- R2: `line_go` is accepted only while `ins_en` and `pal_mode` are both 1. If either is 0 when the strobe comes, nothing happens. If either falls during a line, the line is abandoned with no further `bit_vld`, `req` or `line_done`.
- R3: `src_sel` picks the data pin: 0 selects `src_a`, 1 selects `src_b`, 2 selects `src_c`, and 3 selects none, so every sampled bit is 0.
- R4: Bit k of the line (0-based) occupies a 3-clock cell when (k mod 37) is 9, 18, 27 or 36, and a 4-clock cell otherwise. The 10th bit's valid strobe therefore comes 39 cycles after the start, and the 37th bit's comes 144 cycles after the start.
- R5: Count the edge that accepts `line_go` as edge 0. Bit k is sampled on edge E_k, where E_k is the sum of the cell lengths of bits 0..k. `bit_vld` is high for exactly the one cycle that follows that edge, and `bit_out` then holds the selected pin's value as it was just before the edge.
- R6: A line carries exactly 360 bits. The last group is cut short after 27 bits, the final bit is sampled on edge 1402, and no further bits follow.
- R7: `line_done` is a one-cycle pulse in the cycle after the final `bit_vld`, which makes it the cycle after edge 1403.
- R8: With `req_bit_mode` = 0 (line mode), `req` is high in every active cycle whose index, counted from 0 after edge 0, is at least `req_pos`. `req_len` has no effect.
- R9: With `req_bit_mode` = 1 (bit mode), `req` is high in each cell during the cell positions `req_pos` to `req_pos+req_len-1` that exist in that cell. A `req_len` of 0 gives no pulse.
- R10: A `line_go` that arrives during a line restarts the line from bit 0. The abandoned line produces no `line_done`.
- R11: `req` is 0 whenever no line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_en | input | 1 | Teletext insertion enable |
| pal_mode | input | 1 | High when the encoder runs the PAL standard |
| req_bit_mode | input | 1 | Request form: 0 gives one window per line, 1 gives a pulse per bit |
| src_sel | input | 2 | Data pin select: 0 `src_a`, 1 `src_b`, 2 `src_c`, 3 none |
| req_pos | input | 4 | Request offset in clocks |
| req_len | input | 4 | Request pulse width in clocks (bit mode) |
| line_go | input | 1 | Line-start strobe |
| src_a | input | 1 | Candidate data pin (field vertical-sync pin) |
| src_b | input | 1 | Candidate data pin (progressive vertical-sync pin) |
| src_c | input | 1 | Candidate data pin (chroma bit 0) |
| req | output | 1 | Data request to the upstream source |
| bit_out | output | 1 | Most recent sampled teletext bit |
| bit_vld | output | 1 | One-cycle strobe that qualifies `bit_out` |
| line_done | output | 1 | One-cycle flag at the end of a 360-bit line |

## Verification
The checker watches several properties on every cycle:
- valid strobes never land on adjacent cycles;
- the done flag always comes one cycle after a valid strobe and lasts a single cycle;
- the request is quiet outside a line;
- with the block disabled, it produces no strobe and no active line;
- the bit counter stays inside 360 bits;
- with the empty source selected, it samples only zeros.

Other behaviours can only be shown by the bench's scenarios:
- the exact 4/3 cell cadence and the 144-clock group length;
- the data order on each pin, and rejection of the pins not selected;
- the request shape for each offset and width;
- the 1402-clock line and the restart in the middle of a line.

// File: rtl/txt_ins_pkg.sv
// Package: shared constants and encodings for the teletext insertion timer.
// Assumes a 27 MHz pixel clock and a 6.9375 Mb/s serial source.
package txt_ins_pkg;

    localparam int unsigned TXT_LINE_BITS    = 360; // bits carried by one line
    localparam int unsigned TXT_GROUP_BITS   = 37;  // cadence repeats every group
    localparam int unsigned TXT_SHORT_STRIDE = 9;   // short cell every 9th bit after the first
    localparam int unsigned TXT_LONG_CELL    = 4;   // clocks in a normal cell
    localparam int unsigned TXT_SHORT_CELL   = 3;   // clocks in a shortened cell
    localparam int unsigned TXT_CFG_W        = 4;   // width of request offset/width fields

    // Data pin selection encoding.
    typedef enum logic [1:0] {
        PIN_FIELD_VS = 2'd0,
        PIN_PROG_VS  = 2'd1,
        PIN_CHROMA0  = 2'd2,
        PIN_NONE     = 2'd3
    } pin_sel_e;

    // Request output form.
    typedef enum logic {
        REQ_LINE = 1'b0,
        REQ_BIT  = 1'b1
    } req_mode_e;

endpackage

// File: rtl/txt_src_mux.sv
// Module: txt_src_mux
// Chooses the serial data pin by the two-bit select.
// Assumes the pins are already synchronous to the pixel clock; the "none"
// code returns a constant 0.
module txt_src_mux
    import txt_ins_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       src_a,
    input  logic       src_b,
    input  logic       src_c,
    output logic       din
);

    // Pick one candidate pin, or 0 when no pin is selected.
    always_comb begin
        case (pin_sel_e'(sel))
            PIN_FIELD_VS: din = src_a;
            PIN_PROG_VS:  din = src_b;
            PIN_CHROMA0:  din = src_c;
            default:      din = 1'b0;
        endcase
    end

endmodule

// File: rtl/txt_cadence.sv
// Module: txt_cadence
// Keeps the line, group and cell counters that produce the non-uniform bit
// cell cadence. Inside each group, bit positions that are non-zero multiples
// of SHORT_STRIDE get SHORT_CELL clocks and all others get LONG_CELL clocks.
// Assumes SHORT_CELL <= LONG_CELL and that a start strobe outranks the
// counters' own advance.
module txt_cadence #(
    parameter int unsigned LINE_BITS    = 360,
    parameter int unsigned GROUP_BITS   = 37,
    parameter int unsigned SHORT_STRIDE = 9,
    parameter int unsigned LONG_CELL    = 4,
    parameter int unsigned SHORT_CELL   = 3,
    parameter int unsigned LB_W         = $clog2(LINE_BITS),
    parameter int unsigned GB_W         = $clog2(GROUP_BITS),
    parameter int unsigned CP_W         = $clog2(LONG_CELL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_ok,
    input  logic            line_go,
    output logic            act,
    output logic [CP_W-1:0] cell_pos,
    output logic [LB_W-1:0] line_bit,
    output logic            cell_last,
    output logic            line_last
);

    localparam logic [CP_W-1:0] LONG_M1  = CP_W'(LONG_CELL - 1);
    localparam logic [CP_W-1:0] SHORT_M1 = CP_W'(SHORT_CELL - 1);
    localparam logic [GB_W-1:0] GRP_END  = GB_W'(GROUP_BITS - 1);
    localparam logic [LB_W-1:0] LINE_END = LB_W'(LINE_BITS - 1);

    logic [GB_W-1:0] grp_bit;
    logic            short_cell;
    logic [CP_W-1:0] len_m1;

    // Work out the length of the current cell from the position in the group.
    always_comb begin
        short_cell = (grp_bit != '0) && ((32'(grp_bit) % SHORT_STRIDE) == 0);
        len_m1     = short_cell ? SHORT_M1 : LONG_M1;
        cell_last  = act && (cell_pos == len_m1);
        line_last  = (line_bit == LINE_END);
    end

    // Advance the cell, group and line counters, or restart and stop them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            cell_pos <= '0;
            grp_bit  <= '0;
            line_bit <= '0;
        end else if (!run_ok) begin
            act      <= 1'b0;
            cell_pos <= '0;
            grp_bit  <= '0;
            line_bit <= '0;
        end else if (line_go) begin
            act      <= 1'b1;
            cell_pos <= '0;
            grp_bit  <= '0;
            line_bit <= '0;
        end else if (act) begin
            if (cell_last) begin
                cell_pos <= '0;
                if (line_last) begin
                    act      <= 1'b0;
                    grp_bit  <= '0;
                    line_bit <= '0;
                end else begin
                    line_bit <= line_bit + LB_W'(1);
                    grp_bit  <= (grp_bit == GRP_END) ? '0 : grp_bit + GB_W'(1);
                end
            end else begin
                cell_pos <= cell_pos + CP_W'(1);
            end
        end
    end

endmodule

// File: rtl/txt_bit_capture.sv
// Module: txt_bit_capture
// Samples the selected pin at the last clock of each cell, emits the bit with a
// one-cycle strobe, and raises the done flag one cycle after the final bit.
// Assumes cell_last is already qualified by an active line.
module txt_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic line_go,
    input  logic cell_last,
    input  logic line_last,
    input  logic din,
    output logic bit_out,
    output logic bit_vld,
    output logic line_done
);

    logic take;
    logic fin_q;

    // A sample is taken only when the cell ends with no restart pending.
    always_comb take = run_ok && cell_last && !line_go;

    // Register the sampled bit, its strobe, and the delayed end-of-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_vld   <= 1'b0;
            fin_q     <= 1'b0;
            line_done <= 1'b0;
        end else begin
            bit_vld   <= take;
            fin_q     <= take && line_last;
            line_done <= fin_q;
            if (take) begin
                bit_out <= din;
            end
        end
    end

endmodule

// File: rtl/txt_req_gen.sv
// Module: txt_req_gen
// Drives the upstream request. Line form: high once the clocks elapsed since
// the start reach the offset, until the line ends. Bit form: high for a window
// of cell positions [offset, offset+width).
// Assumes CFG_W+1 bits can hold any cell position.
module txt_req_gen
    import txt_ins_pkg::*;
#(
    parameter int unsigned CFG_W = 4,
    parameter int unsigned CP_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             line_go,
    input  logic             act,
    input  logic             bit_mode,
    input  logic [CP_W-1:0]  cell_pos,
    input  logic [CFG_W-1:0] req_pos,
    input  logic [CFG_W-1:0] req_len,
    output logic             req
);

    localparam int unsigned XW = CFG_W + 1;

    logic [CFG_W-1:0] elapsed;
    logic [XW-1:0]    pos_x;
    logic [XW-1:0]    end_x;
    logic [XW-1:0]    cp_x;
    logic             in_cell;
    logic             in_line;

    // Count the clocks since the start of the line, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (run_ok && line_go) begin
            elapsed <= '0;
        end else if (act && (elapsed != '1)) begin
            elapsed <= elapsed + CFG_W'(1);
        end
    end

    // Decode the request window for the selected form.
    always_comb begin
        pos_x   = {1'b0, req_pos};
        end_x   = pos_x + {1'b0, req_len};
        cp_x    = XW'(cell_pos);
        in_cell = (cp_x >= pos_x) && (cp_x < end_x);
        in_line = (elapsed >= req_pos);
        req     = act && ((req_mode_e'(bit_mode) == REQ_BIT) ? in_cell : in_line);
    end

endmodule

// File: rtl/txt_ins_timer.sv
// Module: txt_ins_timer (top)
// Teletext serial insertion timing generator. Collects one 360-bit line at the
// 4/3-clock cadence from the selected pin and drives the data request.
// Assumes all inputs are synchronous to the 27 MHz pixel clock.
module txt_ins_timer
    import txt_ins_pkg::*;
#(
    parameter int unsigned LINE_BITS    = TXT_LINE_BITS,
    parameter int unsigned GROUP_BITS   = TXT_GROUP_BITS,
    parameter int unsigned SHORT_STRIDE = TXT_SHORT_STRIDE,
    parameter int unsigned LONG_CELL    = TXT_LONG_CELL,
    parameter int unsigned SHORT_CELL   = TXT_SHORT_CELL,
    parameter int unsigned CFG_W        = TXT_CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic             pal_mode,
    input  logic             req_bit_mode,
    input  logic [1:0]       src_sel,
    input  logic [CFG_W-1:0] req_pos,
    input  logic [CFG_W-1:0] req_len,
    input  logic             line_go,
    input  logic             src_a,
    input  logic             src_b,
    input  logic             src_c,
    output logic             req,
    output logic             bit_out,
    output logic             bit_vld,
    output logic             line_done
);

    localparam int unsigned LB_W = $clog2(LINE_BITS);
    localparam int unsigned GB_W = $clog2(GROUP_BITS);
    localparam int unsigned CP_W = $clog2(LONG_CELL);

    logic            run_ok;
    logic            din;
    logic            run_act;
    logic [CP_W-1:0] cell_pos;
    logic [LB_W-1:0] line_bit;
    logic            cell_last;
    logic            line_last;

    // Insertion runs only while it is enabled and the standard is PAL.
    always_comb run_ok = ins_en && pal_mode;

    txt_src_mux u_mux (
        .sel   (src_sel),
        .src_a (src_a),
        .src_b (src_b),
        .src_c (src_c),
        .din   (din)
    );

    txt_cadence #(
        .LINE_BITS    (LINE_BITS),
        .GROUP_BITS   (GROUP_BITS),
        .SHORT_STRIDE (SHORT_STRIDE),
        .LONG_CELL    (LONG_CELL),
        .SHORT_CELL   (SHORT_CELL),
        .LB_W         (LB_W),
        .GB_W         (GB_W),
        .CP_W         (CP_W)
    ) u_cad (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (run_ok),
        .line_go   (line_go),
        .act       (run_act),
        .cell_pos  (cell_pos),
        .line_bit  (line_bit),
        .cell_last (cell_last),
        .line_last (line_last)
    );

    txt_bit_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (run_ok),
        .line_go   (line_go),
        .cell_last (cell_last),
        .line_last (line_last),
        .din       (din),
        .bit_out   (bit_out),
        .bit_vld   (bit_vld),
        .line_done (line_done)
    );

    txt_req_gen #(
        .CFG_W (CFG_W),
        .CP_W  (CP_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok   (run_ok),
        .line_go  (line_go),
        .act      (run_act),
        .bit_mode (req_bit_mode),
        .cell_pos (cell_pos),
        .req_pos  (req_pos),
        .req_len  (req_len),
        .req      (req)
    );

endmodule

// File: rtl/txt_ins_checker.sv
// Module: txt_ins_checker
// Cycle-by-cycle properties of txt_ins_timer, attached by bind.
// Assumes the default line and cell sizes from the package.
module txt_ins_checker
    import txt_ins_pkg::*;
#(
    parameter int unsigned LB_W = $clog2(TXT_LINE_BITS),
    parameter int unsigned CP_W = $clog2(TXT_LONG_CELL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ins_en,
    input logic            pal_mode,
    input logic [1:0]      src_sel,
    input logic            act,
    input logic [CP_W-1:0] cell_pos,
    input logic [LB_W-1:0] line_bit,
    input logic            req,
    input logic            bit_vld,
    input logic            bit_out,
    input logic            line_done
);

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R5

    AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $past(bit_vld)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R7

    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !req); // R11

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_en && pal_mode) |=> (!bit_vld && !act)); // R2

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (32'(line_bit) < TXT_LINE_BITS)); // R6

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && ($past(src_sel) == 2'd3)) |-> !bit_out); // R3

endmodule

bind txt_ins_timer txt_ins_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (ins_en),
    .pal_mode  (pal_mode),
    .src_sel   (src_sel),
    .act       (run_act),
    .cell_pos  (cell_pos),
    .line_bit  (line_bit),
    .req       (req),
    .bit_vld   (bit_vld),
    .bit_out   (bit_out),
    .line_done (line_done)
);

// File: tb/tb_txt_ins_timer.sv
// Bench for txt_ins_timer: a table of line configurations walked by one loop,
// then directed tests for reset, gating, abort and restart.
module tb_txt_ins_timer;

    localparam int CLK_PERIOD = 10;
    localparam int N_LINE     = 360;
    localparam int LAST_CYC   = 1402; // cycle of the final strobe
    localparam int OBS_CYC    = 1406;
    localparam int WATCHDOG   = 200000;

    // Fields: [19:18] sel, [17] bit form, [16:13] offset, [12:9] width, [8:0] seed
    localparam int N_VEC = 7;
    localparam logic [19:0] VEC [0:N_VEC-1] = '{
        {2'd0, 1'b0, 4'd0,  4'd0, 9'h1A5},
        {2'd1, 1'b0, 4'd7,  4'd3, 9'h0F3},
        {2'd2, 1'b1, 4'd0,  4'd1, 9'h155},
        {2'd0, 1'b1, 4'd1,  4'd2, 9'h0C7},
        {2'd2, 1'b1, 4'd3,  4'd9, 9'h111},
        {2'd3, 1'b0, 4'd15, 4'd5, 9'h1FF},
        {2'd1, 1'b1, 4'd2,  4'd0, 9'h0B6}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ins_en, pal_mode, req_bit_mode, line_go;
    logic [1:0] src_sel;
    logic [3:0] req_pos, req_len;
    logic       src_a, src_b, src_c;
    logic       req, bit_out, bit_vld, line_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int last_bits, last_done_cnt, last_done_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    txt_ins_timer dut (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .pal_mode(pal_mode),
        .req_bit_mode(req_bit_mode), .src_sel(src_sel), .req_pos(req_pos),
        .req_len(req_len), .line_go(line_go), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .req(req), .bit_out(bit_out), .bit_vld(bit_vld),
        .line_done(line_done)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // Cell length from the cadence rule: positions 10,19,28,37 of a group are short.
    function automatic int cell_len(input int b);
        int p1 = (b % 37) + 1;
        return (p1 == 10 || p1 == 19 || p1 == 28 || p1 == 37) ? 3 : 4;
    endfunction

    function automatic logic pat(input int b, input logic [8:0] seed);
        logic [8:0] bb = b[8:0];
        return ^(bb & seed);
    endfunction

    task automatic drive_pins(input logic v, input logic [1:0] sel);
        src_a = ~v; src_b = ~v; src_c = ~v;
        case (sel)
            2'd0: src_a = v;
            2'd1: src_b = v;
            2'd2: src_c = v;
            default: begin src_a = 1'b1; src_b = 1'b1; src_c = 1'b1; end
        endcase
    endtask

    // Count strobes, requests and done flags over n cycles.
    task automatic observe_quiet(input int n, output int nv, output int nr, output int nd);
        nv = 0; nr = 0; nd = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nv += int'(bit_vld); nr += int'(req); nd += int'(line_done);
        end
    endtask

    // Start a line and check its bits, request shape and done flag.
    task automatic run_line(input logic [1:0] sel, input logic bm, input int pos,
                            input int len, input logic [8:0] seed);
        int b = 0, p = 0, bits = 0, c10 = -1, c37 = -1;
        int err_v = 0, err_d = 0, err_r = 0, err_dn = 0;
        logic exp_vld = 1'b0, exp_val = 1'b0, exp_fin = 1'b0, exp_done = 1'b0;
        logic er, nd;
        @(negedge clk);
        src_sel = sel; req_bit_mode = bm; req_pos = pos[3:0]; req_len = len[3:0];
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        last_done_cnt = 0; last_done_cyc = -1;
        for (int c = 0; c < OBS_CYC; c++) begin
            if (c > 0) @(negedge clk);
            if (bit_vld !== exp_vld) err_v++;
            if (exp_vld && bit_out !== exp_val) err_d++;
            if (bit_vld) begin
                bits++;
                if (bits == 10) c10 = c;
                if (bits == 37) c37 = c;
            end
            if (line_done !== exp_done) err_dn++;
            if (line_done) begin last_done_cnt++; last_done_cyc = c; end
            if (b < N_LINE) er = bm ? (p >= pos && p < pos + len) : (c >= pos);
            else            er = 1'b0;
            if (req !== er) err_r++;
            nd = exp_vld && exp_fin;
            exp_done = nd;
            exp_vld = 1'b0;
            if (b < N_LINE) begin
                drive_pins(pat(b, seed), sel);
                if (p == cell_len(b) - 1) begin
                    exp_vld = 1'b1;
                    exp_val = (sel == 2'd3) ? 1'b0 : pat(b, seed);
                    exp_fin = (b == N_LINE - 1);
                    b++; p = 0;
                end else begin
                    p++;
                end
            end else begin
                drive_pins(1'b0, 2'd0);
            end
        end
        last_bits = bits;
        chk(err_v == 0, "R5 strobe timing mismatches", err_v, 0);
        chk(err_d == 0, "R3 sampled data mismatches", err_d, 0);
        chk(err_r == 0, bm ? "R9 bit-form request mismatches" : "R8 line-form request mismatches", err_r, 0);
        chk(bits == N_LINE, "R6 bits per line", bits, N_LINE);
        chk(err_dn == 0 && last_done_cnt == 1 && last_done_cyc == LAST_CYC + 1,
            "R7 done cycle", last_done_cyc, LAST_CYC + 1);
        chk(c10 == 39 && c37 == 144, "R4 cadence 10th/37th strobe cycle", c10 * 1000 + c37, 39 * 1000 + 144);
    endtask

    initial begin
        int nv, nr, nd;
        rst_n = 1'b0; ins_en = 1'b0; pal_mode = 1'b0; req_bit_mode = 1'b0;
        line_go = 1'b0; src_sel = 2'd0; req_pos = '0; req_len = '0;
        src_a = 1'b0; src_b = 1'b0; src_c = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        chk({req, bit_out, bit_vld, line_done} == 4'b0, "R1 outputs in reset",
            int'({req, bit_out, bit_vld, line_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req, bit_out, bit_vld, line_done} == 4'b0, "R1 outputs after reset",
            int'({req, bit_out, bit_vld, line_done}), 0);

        // R2: strobe ignored while disabled
        pal_mode = 1'b1; ins_en = 1'b0;
        @(negedge clk); line_go = 1'b1; @(negedge clk); line_go = 1'b0;
        observe_quiet(1500, nv, nr, nd);
        chk(nv + nr + nd == 0, "R2 enable low ignores start", nv + nr + nd, 0);
        // R2: strobe ignored outside PAL
        ins_en = 1'b1; pal_mode = 1'b0;
        @(negedge clk); line_go = 1'b1; @(negedge clk); line_go = 1'b0;
        observe_quiet(1500, nv, nr, nd);
        chk(nv + nr + nd == 0, "R2 non-PAL ignores start", nv + nr + nd, 0);
        pal_mode = 1'b1;

        // Table of line configurations (R3, R4, R5, R6, R7, R8, R9)
        for (int i = 0; i < N_VEC; i++) begin
            run_line(VEC[i][19:18], VEC[i][17], int'(VEC[i][16:13]),
                     int'(VEC[i][12:9]), VEC[i][8:0]);
        end

        // R11: request quiet once the line is over
        observe_quiet(40, nv, nr, nd);
        chk(nr == 0, "R11 request idle after line", nr, 0);

        // R2: dropping the enable mid-line abandons it
        @(negedge clk); req_bit_mode = 1'b0; req_pos = 4'd0; line_go = 1'b1;
        @(negedge clk); line_go = 1'b0;
        repeat (100) @(negedge clk);
        ins_en = 1'b0; @(negedge clk); ins_en = 1'b1;
        observe_quiet(1500, nv, nr, nd);
        chk(nv + nr + nd == 0, "R2 abort on enable drop", nv + nr + nd, 0);

        // R10: a second start mid-line restarts the count
        @(negedge clk); line_go = 1'b1; @(negedge clk); line_go = 1'b0;
        repeat (200) @(negedge clk);
        run_line(2'd1, 1'b1, 1, 3, 9'h19D);
        chk(last_bits == N_LINE && last_done_cnt == 1 && last_done_cyc == LAST_CYC + 1,
            "R10 restart gives one full line", last_bits, N_LINE);

        // R1: reset mid-line ends it
        @(negedge clk); line_go = 1'b1; @(negedge clk); line_go = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({req, bit_out, bit_vld, line_done} == 4'b0, "R1 outputs on mid-line reset",
            int'({req, bit_out, bit_vld, line_done}), 0);
        rst_n = 1'b1;
        observe_quiet(1500, nv, nr, nd);
        chk(nv + nr + nd == 0, "R1 no activity after reset", nv + nr + nd, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule